// File: doc/BRIEF.md
# SD Multi-Block Transfer Sequencer

This block is the control sequencer for the data phase of an SD/SDIO host controller. Software writes a transfer-mode word and a block count. A start pulse then loads them into the sequencer, which holds them for the whole transfer. While the transfer runs, the data path pulses `blk_done` once for each block it finishes. The sequencer counts these pulses and decides when the transfer is over. A transfer can be a single block, a known number of blocks, or an open-ended stream that only an external stop ends.

When a counted transfer ends normally and the auto-stop bit is set, the sequencer raises a stop-command (CMD12) request. It holds that request until the command path acknowledges it, and only then reports completion. In CE-ATA mode the same auto-stop bit has a different meaning: it arms a detector for the device's command-completion signal and does not request a stop command. The sequencer also forwards each data-ready event from the data path, either as a DMA request or as a CPU-service flag.

Top module: `sd_xfer_seq`

## Requirements
- R1: The mode word is decoded as follows. Bit 0 selects DMA. Bit 1 enables block counting. Bit 2 enables auto-stop. Bit 4 sets the direction (0 = write, host to card; 1 = read, card to host). Bit 5 selects multi-block (1) or single-block (0). Bit 3 and bits 15..6 have no effect. `xfer_dir` shows the latched bit 4 while a transfer is busy.
- R2: With bit 5 clear, exactly one block is transferred and the `blk_cnt` value is ignored. `blks_left` reads 1 after start, and the first `blk_done` ends the transfer.
- R3: With bits 5 and 1 both set, `blks_left` loads `blk_cnt` at start and drops by one after each `blk_done`. The transfer ends on the block that takes it to 0.
- R4: With bit 5 set and bit 1 clear, the transfer is infinite. No number of `blk_done` pulses ends it. An `ext_stop` pulse ends it, and `xfer_done` rises one cycle later.
- R5: Without auto-stop, `xfer_done` is a one-cycle pulse in the cycle after the final `blk_done`. `busy` falls in the same cycle.
- R6: With auto-stop set and CE-ATA mode off, `cmd12_req` rises one cycle after the final block and stays high until `cmd12_ack`. `xfer_done` rises one cycle after the acknowledge, never while the request is pending.
- R7: With CE-ATA mode on, auto-stop never raises `cmd12_req`. Instead, start arms a detector. The first `ccs_seen` after that produces a one-cycle `ccs_irq` pulse in the next cycle, and then the detector is disarmed.
- R8: A counted transfer with `blk_cnt` = 0 produces `xfer_done` one cycle after start. `busy` never rises and no stop command is requested.
- R9: During a transfer, each `data_rdy` produces a one-cycle pulse on `dma_req` (bit 0 set) or on `cpu_rdy` (bit 0 clear) in the next cycle. Outside a transfer, `data_rdy` has no effect.
- R10: `abort` returns the sequencer to idle from any state in one cycle. It clears `cmd12_req`, `blks_left` and the detector, and produces no `xfer_done`.
- R11: A start while `busy` is ignored. The counter and the latched mode are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, loads mode and count |
| mode_word | input | 16 | Transfer-mode word |
| blk_cnt | input | 16 | Number of blocks for counted transfers |
| ceata_mode | input | 1 | CE-ATA mode select, latched at start |
| blk_done | input | 1 | Data path finished one block |
| data_rdy | input | 1 | Data path ready for a data access |
| ext_stop | input | 1 | External stop of a running transfer |
| abort | input | 1 | Abort, returns to idle |
| cmd12_ack | input | 1 | Command path accepted the stop request |
| ccs_seen | input | 1 | Command-completion signal detected on the line |
| busy | output | 1 | Transfer in progress |
| xfer_dir | output | 1 | Latched direction, 1 = read |
| blks_left | output | 16 | Remaining-block counter |
| cmd12_req | output | 1 | Stop-command request, held until acknowledged |
| xfer_done | output | 1 | Transfer-complete pulse |
| ccs_irq | output | 1 | Completion-signal interrupt pulse |
| dma_req | output | 1 | DMA request pulse |
| cpu_rdy | output | 1 | CPU-service flag pulse |

## Verification
Every result is registered once, so it becomes visible one cycle after the input that caused it:
- `xfer_done` follows the final `blk_done`, the `ext_stop`, the `cmd12_ack`, or the start of a zero-count transfer.
- `dma_req` and `cpu_rdy` follow `data_rdy`.
- `ccs_irq` follows `ccs_seen`.
- `cmd12_req` and `blks_left` change after the edge that samples `blk_done` or start.

For each input that must end a transfer, the driver records the cycle in which `xfer_done` is due. A monitor compares that cycle against the cycle in which the pulse is actually seen, and treats any unexpected pulse as an error. All other outputs are sampled on the falling edge right after the sampling rising edge.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;

  localparam int MB_DMA    = 0;
  localparam int MB_CNT_EN = 1;
  localparam int MB_AUTO   = 2;
  localparam int MB_DIR    = 4;
  localparam int MB_MULTI  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_STOP = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic multi;
    logic dir;
    logic auto_stop;
    logic cnt_en;
    logic dma;
  } xfer_mode_t;

endpackage

// File: rtl/sd_mode_decode.sv
module sd_mode_decode
  import sd_xfer_pkg::*;
#(
  parameter int MODE_W = 16
) (
  input  logic [MODE_W-1:0] word,
  output xfer_mode_t        mode
);

  logic unused_rsvd;

  always_comb begin
    mode.dma       = word[MB_DMA];
    mode.cnt_en    = word[MB_CNT_EN];
    mode.auto_stop = word[MB_AUTO];
    mode.dir       = word[MB_DIR];
    mode.multi     = word[MB_MULTI];
  end

  assign unused_rsvd = ^{word[3], word[MODE_W-1:MB_MULTI+1]};

endmodule

// File: rtl/sd_blk_counter.sv
module sd_blk_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic             clr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             is_last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec | clr;
    cnt_d  = cnt;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (dec)  cnt_d = cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign is_last = (cnt == ONE);

endmodule

// File: rtl/sd_data_route.sv
module sd_data_route (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic dma_sel,
  input  logic data_rdy,
  output logic dma_req,
  output logic cpu_rdy
);

  logic dma_d, cpu_d;

  always_comb begin
    dma_d = active & data_rdy &  dma_sel;
    cpu_d = active & data_rdy & ~dma_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req <= 1'b0;
      cpu_rdy <= 1'b0;
    end else begin
      dma_req <= dma_d;
      cpu_rdy <= cpu_d;
    end
  end

endmodule

// File: rtl/sd_seq_fsm.sv
module sd_seq_fsm
  import sd_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_mode_t mode_in,
  input  logic       count_zero,
  input  logic       ceata_in,
  input  logic       blk_done,
  input  logic       is_last,
  input  logic       ext_stop,
  input  logic       abort,
  input  logic       cmd12_ack,
  input  logic       ccs_seen,
  output logic       busy,
  output logic       active,
  output logic       load,
  output logic       dec,
  output logic       clr,
  output logic       cmd12_req,
  output logic       xfer_done,
  output logic       ccs_irq,
  output xfer_mode_t mode_q
);

  seq_state_t st_q, st_d;
  xfer_mode_t mode_d;
  logic       req_d, done_d, irq_d;
  logic       armed_q, armed_d;
  logic       ceata_q, ceata_d;
  logic       mode_en;
  logic       counted;

  assign counted = mode_q.multi ? mode_q.cnt_en : 1'b1;

  always_comb begin
    st_d    = st_q;
    req_d   = cmd12_req;
    done_d  = 1'b0;
    irq_d   = 1'b0;
    armed_d = armed_q;
    mode_d  = mode_q;
    ceata_d = ceata_q;
    mode_en = 1'b0;
    load    = 1'b0;
    dec     = 1'b0;
    clr     = 1'b0;
    if (abort) begin
      st_d    = ST_IDLE;
      req_d   = 1'b0;
      armed_d = 1'b0;
      clr     = 1'b1;
    end else begin
      if (armed_q && ccs_seen) begin
        irq_d   = 1'b1;
        armed_d = 1'b0;
      end
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            mode_en = 1'b1;
            mode_d  = mode_in;
            ceata_d = ceata_in;
            armed_d = ceata_in & mode_in.auto_stop;
            load    = 1'b1;
            if (count_zero) done_d = 1'b1;
            else            st_d   = ST_XFER;
          end
        end
        ST_XFER: begin
          if (blk_done && counted) begin
            dec = 1'b1;
            if (is_last) begin
              if (mode_q.auto_stop && !ceata_q) begin
                req_d = 1'b1;
                st_d  = ST_STOP;
              end else begin
                done_d = 1'b1;
                st_d   = ST_IDLE;
              end
            end else if (ext_stop) begin
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end else if (ext_stop) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
        ST_STOP: begin
          if (cmd12_ack) begin
            req_d  = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cmd12_req <= 1'b0;
      xfer_done <= 1'b0;
      ccs_irq   <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      cmd12_req <= req_d;
      xfer_done <= done_d;
      ccs_irq   <= irq_d;
      armed_q   <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ceata_q <= 1'b0;
    end else if (mode_en) begin
      mode_q  <= mode_d;
      ceata_q <= ceata_d;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign active = (st_q == ST_XFER);

endmodule

// File: rtl/sd_xfer_seq.sv
module sd_xfer_seq
  import sd_xfer_pkg::*;
#(
  parameter int MODE_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_word,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic              ceata_mode,
  input  logic              blk_done,
  input  logic              data_rdy,
  input  logic              ext_stop,
  input  logic              abort,
  input  logic              cmd12_ack,
  input  logic              ccs_seen,
  output logic              busy,
  output logic              xfer_dir,
  output logic [CNT_W-1:0]  blks_left,
  output logic              cmd12_req,
  output logic              xfer_done,
  output logic              ccs_irq,
  output logic              dma_req,
  output logic              cpu_rdy
);

  xfer_mode_t       mode_in, mode_q;
  logic [CNT_W-1:0] load_val;
  logic             count_zero, is_last;
  logic             load, dec, clr, active;

  sd_mode_decode #(.MODE_W(MODE_W)) i_dec (
    .word (mode_word),
    .mode (mode_in)
  );

  always_comb begin
    if (!mode_in.multi)       load_val = CNT_W'(1);
    else if (!mode_in.cnt_en) load_val = '0;
    else                      load_val = blk_cnt;
    count_zero = mode_in.multi & mode_in.cnt_en & (blk_cnt == '0);
  end

  sd_blk_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .dec      (dec),
    .clr      (clr),
    .load_val (load_val),
    .cnt      (blks_left),
    .is_last  (is_last)
  );

  sd_seq_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_in    (mode_in),
    .count_zero (count_zero),
    .ceata_in   (ceata_mode),
    .blk_done   (blk_done),
    .is_last    (is_last),
    .ext_stop   (ext_stop),
    .abort      (abort),
    .cmd12_ack  (cmd12_ack),
    .ccs_seen   (ccs_seen),
    .busy       (busy),
    .active     (active),
    .load       (load),
    .dec        (dec),
    .clr        (clr),
    .cmd12_req  (cmd12_req),
    .xfer_done  (xfer_done),
    .ccs_irq    (ccs_irq),
    .mode_q     (mode_q)
  );

  sd_data_route i_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .dma_sel  (mode_q.dma),
    .data_rdy (data_rdy),
    .dma_req  (dma_req),
    .cpu_rdy  (cpu_rdy)
  );

  assign xfer_dir = mode_q.dir;

endmodule

// File: rtl/sd_xfer_seq_chk.sv
module sd_xfer_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             blk_done,
  input logic             abort,
  input logic             cmd12_ack,
  input logic             busy,
  input logic [CNT_W-1:0] blks_left,
  input logic             cmd12_req,
  input logic             xfer_done,
  input logic             ccs_irq,
  input logic             dma_req,
  input logic             cpu_rdy
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd12_req && !cmd12_ack && !abort |=> cmd12_req); // R6

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd12_req |-> busy); // R6

  AST_NO_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd12_req |-> !xfer_done); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !cmd12_req && !xfer_done); // R10

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && cpu_rdy)); // R9

  AST_IDLE_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !dma_req && !cpu_rdy); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !blk_done && !abort |=> $stable(blks_left)); // R11

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ccs_irq && !start |=> !ccs_irq); // R7

endmodule

bind sd_xfer_seq sd_xfer_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .blk_done  (blk_done),
  .abort     (abort),
  .cmd12_ack (cmd12_ack),
  .busy      (busy),
  .blks_left (blks_left),
  .cmd12_req (cmd12_req),
  .xfer_done (xfer_done),
  .ccs_irq   (ccs_irq),
  .dma_req   (dma_req),
  .cpu_rdy   (cpu_rdy)
);

// File: tb/test_sd_xfer_seq.sv
`timescale 1ns/1ps
module test_sd_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mode_word = '0;
  logic [15:0] blk_cnt = '0;
  logic        ceata_mode = 1'b0;
  logic        blk_done = 1'b0;
  logic        data_rdy = 1'b0;
  logic        ext_stop = 1'b0;
  logic        abort = 1'b0;
  logic        cmd12_ack = 1'b0;
  logic        ccs_seen = 1'b0;
  logic        busy, xfer_dir, cmd12_req, xfer_done, ccs_irq, dma_req, cpu_rdy;
  logic [15:0] blks_left;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int    due_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sd_xfer_seq i_sd_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .blk_cnt(blk_cnt), .ceata_mode(ceata_mode), .blk_done(blk_done),
    .data_rdy(data_rdy), .ext_stop(ext_stop), .abort(abort),
    .cmd12_ack(cmd12_ack), .ccs_seen(ccs_seen), .busy(busy),
    .xfer_dir(xfer_dir), .blks_left(blks_left), .cmd12_req(cmd12_req),
    .xfer_done(xfer_done), .ccs_irq(ccs_irq), .dma_req(dma_req),
    .cpu_rdy(cpu_rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_done(input string tag);
    due_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  // monitor: each completion pulse must match the next expected item
  always @(negedge clk) begin
    int    d;
    string t;
    if (rst_n && xfer_done) begin
      checks++;
      if (due_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected xfer_done at cycle %0d, expected none", cyc);
      end else begin
        d = due_q.pop_front();
        t = tag_q.pop_front();
        if (d != cyc) begin
          errors++;
          $display("FAIL %s xfer_done cycle actual %0d expected %0d", t, cyc, d);
        end
      end
    end
  end

  task automatic do_start(input logic [15:0] mw, input logic [15:0] cnt, input bit fin, input string tag);
    @(negedge clk);
    if (fin) expect_done(tag);
    mode_word = mw; blk_cnt = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_blk(input bit fin, input string tag);
    @(negedge clk);
    if (fin) expect_done(tag);
    blk_done = 1'b1;
    @(negedge clk);
    blk_done = 1'b0;
  endtask

  task automatic do_ack(input string tag);
    @(negedge clk);
    expect_done(tag);
    cmd12_ack = 1'b1;
    @(negedge clk);
    cmd12_ack = 1'b0;
  endtask

  task automatic do_stop(input string tag);
    @(negedge clk);
    expect_done(tag);
    ext_stop = 1'b1;
    @(negedge clk);
    ext_stop = 1'b0;
  endtask

  task automatic do_rdy();
    @(negedge clk); data_rdy = 1'b1;
    @(negedge clk); data_rdy = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic do_ccs();
    @(negedge clk); ccs_seen = 1'b1;
    @(negedge clk); ccs_seen = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset blks_left", blks_left, 0);
    chk("R6 reset cmd12_req", cmd12_req, 0);
    chk("R9 reset dma_req", dma_req, 0);

    // R9 data_rdy while idle has no effect
    do_rdy();
    chk("R9 idle dma_req", dma_req, 0);
    chk("R9 idle cpu_rdy", cpu_rdy, 0);

    // R2 single-block write with DMA, count field ignored
    do_start(16'h0001, 16'd7, 0, "");
    chk("R2 single busy", busy, 1);
    chk("R2 single blks_left", blks_left, 1);
    chk("R1 dir write", xfer_dir, 0);
    do_rdy();
    chk("R9 dma_req", dma_req, 1);
    chk("R9 cpu_rdy off", cpu_rdy, 0);
    @(negedge clk);
    chk("R9 dma_req pulse", dma_req, 0);
    do_blk(1, "R2 single done");
    chk("R5 busy falls", busy, 0);

    // R3 counted read, CPU access, reserved bits set (R1)
    do_start(16'h803A, 16'd3, 0, "");
    chk("R3 load", blks_left, 3);
    chk("R1 dir read", xfer_dir, 1);
    do_rdy();
    chk("R9 cpu_rdy", cpu_rdy, 1);
    chk("R9 dma_req off", dma_req, 0);
    do_blk(0, "");
    chk("R3 dec", blks_left, 2);
    do_start(16'h0001, 16'd9, 0, "");
    chk("R11 start ignored count", blks_left, 2);
    chk("R11 start ignored dir", xfer_dir, 1);
    do_blk(0, "");
    chk("R3 dec2", blks_left, 1);
    do_blk(1, "R3 counted done");
    chk("R3 end count", blks_left, 0);
    chk("R5 end busy", busy, 0);

    // R6 auto-stop
    do_start(16'h0026, 16'd2, 0, "");
    do_blk(0, "");
    do_blk(0, "");
    chk("R6 req raised", cmd12_req, 1);
    chk("R6 busy in stop", busy, 1);
    repeat (3) @(negedge clk);
    chk("R6 req held", cmd12_req, 1);
    do_ack("R6 done after ack");
    chk("R6 req cleared", cmd12_req, 0);

    // R7 CE-ATA: no stop command, detector fires once
    ceata_mode = 1'b1;
    do_start(16'h0026, 16'd1, 0, "");
    do_blk(1, "R7 ceata done");
    chk("R7 no cmd12", cmd12_req, 0);
    do_ccs();
    chk("R7 ccs_irq", ccs_irq, 1);
    @(negedge clk);
    chk("R7 ccs_irq pulse", ccs_irq, 0);
    do_ccs();
    chk("R7 disarmed", ccs_irq, 0);
    ceata_mode = 1'b0;

    // R8 zero count
    do_start(16'h0026, 16'd0, 1, "R8 zero count done");
    chk("R8 not busy", busy, 0);
    chk("R8 no cmd12", cmd12_req, 0);

    // R4 infinite
    do_start(16'h0020, 16'd5, 0, "");
    for (int i = 0; i < 6; i++) do_blk(0, "");
    chk("R4 still busy", busy, 1);
    do_stop("R4 stop done");
    chk("R4 idle after stop", busy, 0);

    // R10 abort while stop command pending and mid transfer
    do_start(16'h0026, 16'd1, 0, "");
    do_blk(0, "");
    chk("R10 req before abort", cmd12_req, 1);
    do_abort();
    chk("R10 req cleared", cmd12_req, 0);
    chk("R10 idle", busy, 0);
    do_start(16'h0022, 16'd4, 0, "");
    do_blk(0, "");
    do_abort();
    chk("R10 abort busy", busy, 0);
    chk("R10 abort count", blks_left, 0);

    repeat (4) @(negedge clk);
    chk("R5 all completions seen", due_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule